// File: doc/BRIEF.md
# UDP/IPv4 Ethernet Frame Transmitter

This block turns a stream of application bytes into complete Ethernet II frames that carry one IPv4/UDP datagram each. The frames leave one octet per clock on an 8-bit transmit interface (`txd`, `tx_en`) that runs at 125 MHz. When the block is idle and the source raises `pl_valid`, it samples the requested payload length and the address and port configuration. It then sends the preamble, the start-of-frame delimiter, the MAC, IPv4 and UDP headers, the payload, any zero padding needed to reach the minimum frame size, and the CRC-32 frame check sequence. After the frame it holds the line idle for the inter-frame gap before it accepts the next request.

The payload source moves bytes with a valid/ready handshake. Ready is raised only while the payload portion of the frame is being sent. The source must present a byte on every cycle in which ready is high. If valid is low in such a cycle, the frame is cut short. A broadcast input replaces both destination addresses with the all-ones address. The DDR pin conversion, the receive direction and any address-resolution traffic belong to neighbouring blocks.

Top module: `udp_frame_tx`

## Requirements
- R1: Every frame begins on `txd` with seven 0x55 octets followed by one 0xD5 octet. The first of these octets is the first octet with `tx_en` high.
- R2: `tx_en` stays high without a break from the first preamble octet through the last FCS octet. A complete frame is 8 + 42 + max(L, 18) + 4 octets long, where L is the effective UDP payload length.
- R3: Frame octets 8 to 49 carry the header, with these fields at these frame octet indices:
  - destination MAC at 8..13 and source MAC at 14..19;
  - EtherType 0x0800 at 20..21;
  - 0x45, 0x00 at 22..23;
  - IP total length 28+L at 24..25;
  - identification and flags/fragment, all zero, at 26..29;
  - TTL 64 at 30 and protocol 17 at 31;
  - checksum at 32..33;
  - source IP at 34..37 and destination IP at 38..41;
  - source port at 42..43 and destination port at 44..45;
  - UDP length 8+L at 46..47;
  - UDP checksum 0x0000 at 48..49.
  
  All multi-octet fields are sent most-significant octet first. Addresses, ports and length are sampled when the frame starts.
- R4: The ones'-complement sum of the ten 16-bit words at octets 22..41, checksum included, equals 0xFFFF.
- R5: Payload bytes appear at octets 50 onward, in the order they were handed over. Each accepted byte appears on `txd` the cycle after its handshake. `pl_ready` is high only in cycles whose next output octet is a payload octet.
- R6: When L < 18, zero octets follow the payload until octet 67 inclusive, so that the Ethernet payload is 46 octets.
- R7: The last four octets are the CRC-32 over octets 8 through the end of the padding. The CRC uses the reflected 0x04C11DB7 polynomial with a 0xFFFFFFFF start value, and the result is inverted and sent least-significant octet first.
- R8: At least 12 cycles with `tx_en` low separate the end of one frame from the next preamble. Exactly 12 separate them when a request is already waiting.
- R9: With `cfg_bcast` high at frame start, the destination MAC is FF:FF:FF:FF:FF:FF and the destination IP is 255.255.255.255, whatever the configured destinations are.
- R10: A requested length above 1472 is treated as 1472, which makes the IP total length 1500 and the frame 1526 octets long.
- R11: If `pl_valid` is low in a cycle with `pl_ready` high, `tx_en` is low the next cycle. No FCS is sent, and the gap of R8 still applies before the next frame.
- R12: After reset, `tx_en`, `txd` and `pl_ready` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz octet clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_src_mac | input | 48 | Source MAC address |
| cfg_dst_mac | input | 48 | Destination MAC address (unicast) |
| cfg_src_ip | input | 32 | Source IPv4 address |
| cfg_dst_ip | input | 32 | Destination IPv4 address (unicast) |
| cfg_src_port | input | 16 | UDP source port |
| cfg_dst_port | input | 16 | UDP destination port |
| cfg_bcast | input | 1 | Send to the all-ones MAC and IP addresses |
| pl_valid | input | 1 | Payload byte valid; while idle, also requests a frame |
| pl_data | input | 8 | Payload byte |
| pl_len | input | 11 | UDP payload length, sampled at frame start |
| pl_ready | output | 1 | Payload byte taken this cycle if valid |
| txd | output | 8 | Transmit octet |
| tx_en | output | 1 | Transmit enable |

## Verification
On every cycle, the embedded assertions check these behaviours:
- a frame always opens with 0x55;
- at least 12 idle cycles precede any frame start;
- no completed frame falls below 72 octets;
- an accepted payload byte shows up on `txd` one cycle later;
- an underrun drops `tx_en` at once;
- the header checksum sums to 0xFFFF.

Only the bench scenarios can show the following:
- the exact octet contents of the headers;
- the broadcast substitution;
- the zero padding and the FCS value;
- the clamp of oversized lengths;
- the exact 12-cycle spacing of back-to-back frames.

The bench compares every captured frame against a frame it builds itself.

// File: rtl/udptx_pkg.sv
package udptx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_HDR, ST_PAY, ST_PAD, ST_FCS, ST_GAP
  } tx_state_e;

  // MAC (14) + IPv4 (20) + UDP (8) header octets
  localparam int HDR_OCTETS  = 42;
  localparam int HDR_BITS    = 8 * HDR_OCTETS;
  localparam int IPUDP_OCTETS = 28;

  // One octet of the reflected CRC-32, LSB of the octet first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB8_8320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // Fold a 32-bit accumulator into a 16-bit ones'-complement sum.
  function automatic logic [15:0] csum_fold(input logic [31:0] s);
    logic [31:0] t;
    t = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
    return t[15:0];
  endfunction

endpackage

// File: rtl/udptx_hdr_build.sv
module udptx_hdr_build
  import udptx_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic [47:0]            src_mac,
  input  logic [47:0]            dst_mac,
  input  logic [31:0]            src_ip,
  input  logic [31:0]            dst_ip,
  input  logic [15:0]            src_port,
  input  logic [15:0]            dst_port,
  input  logic                   bcast,
  input  logic [LEN_W-1:0]       udp_len,
  output logic [HDR_BITS-1:0]    hdr,
  output logic [31:0]            word_sum,
  output logic [15:0]            ip_csum
);

  logic [47:0] eff_mac;
  logic [31:0] eff_ip;
  logic [15:0] ip_total;
  logic [15:0] udp_total;
  logic [15:0] words [10];

  assign eff_mac   = bcast ? 48'hFFFF_FFFF_FFFF : dst_mac;
  assign eff_ip    = bcast ? 32'hFFFF_FFFF : dst_ip;
  assign ip_total  = 16'(IPUDP_OCTETS) + 16'(udp_len);
  assign udp_total = 16'd8 + 16'(udp_len);

  // IPv4 header words with the checksum field taken as zero
  always_comb begin
    words[0] = 16'h4500;
    words[1] = ip_total;
    words[2] = 16'h0000;
    words[3] = 16'h0000;
    words[4] = {8'd64, 8'd17};
    words[5] = 16'h0000;
    words[6] = src_ip[31:16];
    words[7] = src_ip[15:0];
    words[8] = eff_ip[31:16];
    words[9] = eff_ip[15:0];
    word_sum = '0;
    for (int i = 0; i < 10; i++) word_sum = word_sum + {16'h0, words[i]};
  end

  assign ip_csum = ~csum_fold(word_sum);

  assign hdr = {eff_mac, src_mac, 16'h0800,
                16'h4500, ip_total, 16'h0000, 16'h0000,
                8'd64, 8'd17, ip_csum, src_ip, eff_ip,
                src_port, dst_port, udp_total, 16'h0000};

endmodule

// File: rtl/udptx_fcs.sv
module udptx_fcs
  import udptx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        adv,
  input  logic [7:0]  din,
  output logic [31:0] crc
);

  always_ff @(posedge clk) begin
    if (!rst_n)    crc <= 32'hFFFF_FFFF;
    else if (init) crc <= 32'hFFFF_FFFF;
    else if (adv)  crc <= crc32_step(crc, din);
  end

endmodule

// File: rtl/udp_frame_tx.sv
module udp_frame_tx
  import udptx_pkg::*;
#(
  parameter int MIN_ETH_PAYLOAD = 46,
  parameter int MAX_ETH_PAYLOAD = 1500,
  parameter int GAP_OCTETS      = 12,
  parameter int PRE_OCTETS      = 7,
  parameter int LEN_W           = $clog2(MAX_ETH_PAYLOAD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [47:0]       cfg_src_mac,
  input  logic [47:0]       cfg_dst_mac,
  input  logic [31:0]       cfg_src_ip,
  input  logic [31:0]       cfg_dst_ip,
  input  logic [15:0]       cfg_src_port,
  input  logic [15:0]       cfg_dst_port,
  input  logic              cfg_bcast,
  input  logic              pl_valid,
  input  logic [7:0]        pl_data,
  input  logic [LEN_W-1:0]  pl_len,
  output logic              pl_ready,
  output logic [7:0]        txd,
  output logic              tx_en
);

  localparam int MAX_UDP   = MAX_ETH_PAYLOAD - IPUDP_OCTETS;
  localparam int MIN_BODY  = MIN_ETH_PAYLOAD - IPUDP_OCTETS;
  localparam int MIN_FRAME = PRE_OCTETS + 1 + 14 + MIN_ETH_PAYLOAD + 4;
  localparam int MAX_FRAME = PRE_OCTETS + 1 + 14 + MAX_ETH_PAYLOAD + 4;
  localparam int RUN_W     = $clog2(MAX_FRAME + 1);
  localparam int IDLE_W    = $clog2(GAP_OCTETS + 1);

  localparam logic [LEN_W-1:0]  MAX_UDP_L  = LEN_W'(MAX_UDP);
  localparam logic [LEN_W-1:0]  MIN_BODY_L = LEN_W'(MIN_BODY);
  localparam logic [LEN_W-1:0]  PAD_LAST   = LEN_W'(MIN_BODY - 1);
  localparam logic [LEN_W-1:0]  HDR_LAST   = LEN_W'(HDR_OCTETS - 1);
  localparam logic [LEN_W-1:0]  PRE_LAST   = LEN_W'(PRE_OCTETS);
  localparam logic [LEN_W-1:0]  GAP_LAST   = LEN_W'(GAP_OCTETS - 1);
  localparam logic [LEN_W-1:0]  FCS_LAST   = LEN_W'(3);
  localparam logic [IDLE_W-1:0] GAP_SAT    = IDLE_W'(GAP_OCTETS);
  localparam logic [RUN_W-1:0]  MIN_RUN    = RUN_W'(MIN_FRAME);

  tx_state_e           state, nstate;
  logic [LEN_W-1:0]    cnt, ncnt;
  logic [LEN_W-1:0]    len_q, len_in;
  logic [HDR_BITS-1:0] hdr_sr, hdr_new;
  logic [31:0]         hb_sum;
  logic [15:0]         hb_csum;
  logic [31:0]         crc;
  logic [31:0]         crc_fin;
  logic [7:0]          nxt_byte;
  logic                nxt_en;

  // Internal events, named for the assertions
  logic start_ev;     // frame accepted this cycle
  logic abort_ev;     // payload underrun this cycle
  logic crc_adv;      // octet covered by the FCS
  logic abort_q;      // underrun, aligned with tx_en

  assign start_ev = (state == ST_IDLE) && pl_valid;
  assign len_in   = (pl_len > MAX_UDP_L) ? MAX_UDP_L : pl_len;
  assign pl_ready = (state == ST_PAY);
  assign crc_fin  = ~crc;

  udptx_hdr_build #(.LEN_W(LEN_W)) u_hdr (
    .src_mac  (cfg_src_mac),
    .dst_mac  (cfg_dst_mac),
    .src_ip   (cfg_src_ip),
    .dst_ip   (cfg_dst_ip),
    .src_port (cfg_src_port),
    .dst_port (cfg_dst_port),
    .bcast    (cfg_bcast),
    .udp_len  (len_in),
    .hdr      (hdr_new),
    .word_sum (hb_sum),
    .ip_csum  (hb_csum)
  );

  udptx_fcs u_fcs (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (start_ev),
    .adv   (crc_adv),
    .din   (nxt_byte),
    .crc   (crc)
  );

  always_comb begin
    nstate   = state;
    ncnt     = cnt;
    nxt_en   = 1'b0;
    nxt_byte = 8'h00;
    crc_adv  = 1'b0;
    abort_ev = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (pl_valid) begin
          nxt_en   = 1'b1;
          nxt_byte = 8'h55;
          nstate   = ST_PRE;
          ncnt     = LEN_W'(1);
        end
      end
      ST_PRE: begin
        nxt_en = 1'b1;
        if (cnt == PRE_LAST) begin
          nxt_byte = 8'hD5;
          nstate   = ST_HDR;
          ncnt     = '0;
        end else begin
          nxt_byte = 8'h55;
          ncnt     = cnt + 1'b1;
        end
      end
      ST_HDR: begin
        nxt_en   = 1'b1;
        nxt_byte = hdr_sr[HDR_BITS-1 -: 8];
        crc_adv  = 1'b1;
        if (cnt == HDR_LAST) begin
          ncnt   = '0;
          nstate = (len_q == '0) ? ST_PAD : ST_PAY;
        end else begin
          ncnt = cnt + 1'b1;
        end
      end
      ST_PAY: begin
        if (pl_valid) begin
          nxt_en   = 1'b1;
          nxt_byte = pl_data;
          crc_adv  = 1'b1;
          if (cnt == len_q - 1'b1) begin
            if (cnt + 1'b1 < MIN_BODY_L) begin
              nstate = ST_PAD;
              ncnt   = cnt + 1'b1;
            end else begin
              nstate = ST_FCS;
              ncnt   = '0;
            end
          end else begin
            ncnt = cnt + 1'b1;
          end
        end else begin
          abort_ev = 1'b1;
          nstate   = ST_GAP;
          ncnt     = '0;
        end
      end
      ST_PAD: begin
        nxt_en  = 1'b1;
        crc_adv = 1'b1;
        if (cnt == PAD_LAST) begin
          nstate = ST_FCS;
          ncnt   = '0;
        end else begin
          ncnt = cnt + 1'b1;
        end
      end
      ST_FCS: begin
        nxt_en = 1'b1;
        case (cnt[1:0])
          2'd0:    nxt_byte = crc_fin[7:0];
          2'd1:    nxt_byte = crc_fin[15:8];
          2'd2:    nxt_byte = crc_fin[23:16];
          default: nxt_byte = crc_fin[31:24];
        endcase
        if (cnt == FCS_LAST) begin
          nstate = ST_GAP;
          ncnt   = '0;
        end else begin
          ncnt = cnt + 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt == GAP_LAST) begin
          nstate = ST_IDLE;
          ncnt   = '0;
        end else begin
          ncnt = cnt + 1'b1;
        end
      end
      default: begin
        nstate = ST_IDLE;
        ncnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      len_q   <= '0;
      hdr_sr  <= '0;
      txd     <= 8'h00;
      tx_en   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state   <= nstate;
      cnt     <= ncnt;
      txd     <= nxt_byte;
      tx_en   <= nxt_en;
      abort_q <= abort_ev;
      if (start_ev) begin
        len_q  <= len_in;
        hdr_sr <= hdr_new;
      end else if (state == ST_HDR) begin
        hdr_sr <= {hdr_sr[HDR_BITS-9:0], 8'h00};
      end
    end
  end

  // ---------------- assertions ----------------
  logic [IDLE_W-1:0] idle_run;  // idle octets since last frame, saturating
  logic [RUN_W-1:0]  run_len;   // octets of the frame now on the line

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_run <= GAP_SAT;
      run_len  <= '0;
    end else begin
      if (tx_en) idle_run <= '0;
      else if (idle_run != GAP_SAT) idle_run <= idle_run + 1'b1;
      run_len <= tx_en ? run_len + 1'b1 : '0;
    end
  end

  assert_preamble_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (txd == 8'h55));

  assert_min_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> (abort_q || run_len >= MIN_RUN));

  assert_ip_csum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |-> (csum_fold(hb_sum + {16'h0, hb_csum}) == 16'hFFFF));

  assert_payload_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_ready && pl_valid) |=> (tx_en && txd == $past(pl_data)));

  assert_idle_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (idle_run >= GAP_SAT));

  assert_underrun_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_ready && !pl_valid) |=> !tx_en);

endmodule

// File: tb/tb_udp_frame_tx.sv
module tb_udp_frame_tx;

  localparam int CLK_PERIOD = 8;
  localparam int MAXU       = 1472;
  localparam int FBUF       = 1600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] cfg_src_mac = 48'h02_11_22_33_44_55;
  logic [47:0] cfg_dst_mac = 48'h0A_BB_CC_DD_EE_01;
  logic [31:0] cfg_src_ip  = 32'hC0A8_0102;
  logic [31:0] cfg_dst_ip  = 32'hC0A8_0164;
  logic [15:0] cfg_src_port = 16'd4000;
  logic [15:0] cfg_dst_port = 16'd5001;
  logic        cfg_bcast = 1'b0;
  logic        pl_valid = 1'b0;
  logic [7:0]  pl_data = 8'h00;
  logic [10:0] pl_len = '0;
  logic        pl_ready;
  logic [7:0]  txd;
  logic        tx_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  udp_frame_tx dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_src_mac(cfg_src_mac), .cfg_dst_mac(cfg_dst_mac),
    .cfg_src_ip(cfg_src_ip), .cfg_dst_ip(cfg_dst_ip),
    .cfg_src_port(cfg_src_port), .cfg_dst_port(cfg_dst_port),
    .cfg_bcast(cfg_bcast),
    .pl_valid(pl_valid), .pl_data(pl_data), .pl_len(pl_len),
    .pl_ready(pl_ready), .txd(txd), .tx_en(tx_en)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- expected frames (two slots) ----------------
  logic [7:0] exp_b [2][FBUF];
  int  exp_len [2];
  int  exp_n   [2];
  int  exp_pay [2];
  bit  exp_abort [2];
  bit  exp_bc  [2];
  logic [7:0] pay [FBUF];
  int  sent_cnt = 0;

  function automatic logic [31:0] bench_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    return r;
  endfunction

  task automatic build_exp(input int slot, input int n, input int sent, input bit ab);
    int p;
    logic [47:0] dm;
    logic [31:0] di;
    logic [31:0] s;
    logic [31:0] c;
    logic [15:0] tl;
    logic [15:0] ul;
    p  = 0;
    dm = cfg_bcast ? 48'hFFFF_FFFF_FFFF : cfg_dst_mac;
    di = cfg_bcast ? 32'hFFFF_FFFF : cfg_dst_ip;
    tl = 16'(28 + n);
    ul = 16'(8 + n);
    for (int i = 0; i < 7; i++) begin exp_b[slot][p] = 8'h55; p++; end
    exp_b[slot][p] = 8'hD5; p++;
    for (int i = 5; i >= 0; i--) begin exp_b[slot][p] = dm[8*i +: 8]; p++; end
    for (int i = 5; i >= 0; i--) begin exp_b[slot][p] = cfg_src_mac[8*i +: 8]; p++; end
    exp_b[slot][p] = 8'h08; p++; exp_b[slot][p] = 8'h00; p++;
    exp_b[slot][p] = 8'h45; p++; exp_b[slot][p] = 8'h00; p++;
    exp_b[slot][p] = tl[15:8]; p++; exp_b[slot][p] = tl[7:0]; p++;
    for (int i = 0; i < 4; i++) begin exp_b[slot][p] = 8'h00; p++; end
    exp_b[slot][p] = 8'd64; p++; exp_b[slot][p] = 8'd17; p++;
    exp_b[slot][p] = 8'h00; p++; exp_b[slot][p] = 8'h00; p++;
    for (int i = 3; i >= 0; i--) begin exp_b[slot][p] = cfg_src_ip[8*i +: 8]; p++; end
    for (int i = 3; i >= 0; i--) begin exp_b[slot][p] = di[8*i +: 8]; p++; end
    exp_b[slot][p] = cfg_src_port[15:8]; p++; exp_b[slot][p] = cfg_src_port[7:0]; p++;
    exp_b[slot][p] = cfg_dst_port[15:8]; p++; exp_b[slot][p] = cfg_dst_port[7:0]; p++;
    exp_b[slot][p] = ul[15:8]; p++; exp_b[slot][p] = ul[7:0]; p++;
    exp_b[slot][p] = 8'h00; p++; exp_b[slot][p] = 8'h00; p++;
    s = 0;
    for (int i = 22; i < 42; i += 2) s = s + {16'h0, exp_b[slot][i], exp_b[slot][i+1]};
    while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    exp_b[slot][32] = ~s[15:8];
    exp_b[slot][33] = ~s[7:0];
    for (int i = 0; i < sent; i++) begin exp_b[slot][p] = pay[i]; p++; end
    if (!ab) begin
      while (p < 68) begin exp_b[slot][p] = 8'h00; p++; end
      c = 32'hFFFF_FFFF;
      for (int i = 8; i < p; i++) c = bench_crc(c, exp_b[slot][i]);
      c = ~c;
      for (int i = 0; i < 4; i++) begin exp_b[slot][p] = c[8*i +: 8]; p++; end
    end
    exp_len[slot]   = p;
    exp_n[slot]     = n;
    exp_pay[slot]   = sent;
    exp_abort[slot] = ab;
    exp_bc[slot]    = cfg_bcast;
  endtask

  // ---------------- monitor ----------------
  logic [7:0] got [FBUF];
  int  got_len = 0;
  int  idle_cnt = 0;
  bit  seen_frame = 0;
  int  last_gap = 0;
  int  last_len = 0;
  int  frames_rx = 0;
  bit  ready_bad = 0;

  function automatic int mism(input int slot, input int lo, input int hi);
    for (int i = lo; i < hi; i++) begin
      if (i >= got_len) return i;
      if (got[i] !== exp_b[slot][i]) return i;
    end
    return -1;
  endfunction

  task automatic check_frame();
    int slot;
    int m;
    int ei;
    logic [31:0] s;
    slot = frames_rx % 2;
    chk(got_len == exp_len[slot], exp_abort[slot] ? "R11 aborted length" : "R2 frame length",
        got_len, exp_len[slot]);
    m = mism(slot, 0, 8);
    ei = (m < 0) ? 0 : m;
    chk(m < 0, "R1 preamble/SFD", (m < 0) ? 0 : int'(got[ei]), int'(exp_b[slot][ei]));
    m = mism(slot, 8, 50);
    ei = (m < 0) ? 0 : m;
    chk(m < 0, exp_bc[slot] ? "R9 broadcast header" : "R3 header",
        (m < 0) ? 0 : int'(got[ei]), int'(exp_b[slot][ei]));
    s = 0;
    if (got_len >= 42)
      for (int i = 22; i < 42; i += 2) s = s + {16'h0, got[i], got[i+1]};
    while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    chk(s[15:0] == 16'hFFFF, "R4 header checksum", int'(s[15:0]), 32'hFFFF);
    m = mism(slot, 50, 50 + exp_pay[slot]);
    ei = (m < 0) ? 0 : m;
    chk(m < 0 && !ready_bad, "R5 payload/ready", (m < 0) ? int'(ready_bad) : int'(got[ei]),
        (m < 0) ? 0 : int'(exp_b[slot][ei]));
    if (!exp_abort[slot]) begin
      if (exp_n[slot] < 18) begin
        m = mism(slot, 50 + exp_n[slot], 68);
        chk(m < 0, "R6 zero padding", m, -1);
      end
      m = mism(slot, exp_len[slot] - 4, exp_len[slot]);
      ei = (m < 0) ? 0 : m;
      chk(m < 0, "R7 FCS", (m < 0) ? 0 : int'(got[ei]), int'(exp_b[slot][ei]));
    end
    last_len = got_len;
    ready_bad = 0;
    frames_rx++;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_en) begin
        if (got_len == 0 && seen_frame) begin
          last_gap = idle_cnt;
          chk(idle_cnt >= 12, "R8 inter-frame gap", idle_cnt, 12);
        end
        if (got_len < FBUF) got[got_len] = txd;
        got_len++;
        if (pl_ready && (got_len < 50 || got_len >= 50 + exp_n[frames_rx % 2])) ready_bad = 1;
      end else begin
        if (got_len > 0) begin
          check_frame();
          got_len = 0;
          seen_frame = 1;
          idle_cnt = 0;
        end
        idle_cnt++;
        if (pl_ready) ready_bad = 1;
      end
    end
  end

  // ---------------- source ----------------
  task automatic send_frame(input int len, input int drop_at);
    int n;
    int idx;
    bit started;
    bit rdy;
    int slot;
    n = (len > MAXU) ? MAXU : len;
    for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
    slot = sent_cnt % 2;
    build_exp(slot, n, (drop_at >= 0) ? drop_at : n, drop_at >= 0);
    sent_cnt++;
    @(negedge clk);
    pl_len   = 11'(len);
    pl_valid = 1'b1;
    pl_data  = (n > 0) ? pay[0] : 8'h00;
    idx = 0; started = 0; rdy = 0;
    forever begin
      @(negedge clk);
      if (rdy) idx++;
      if (tx_en) started = 1;
      if (started && idx >= n) begin pl_valid = 1'b0; break; end
      if (drop_at >= 0 && idx == drop_at) begin pl_valid = 1'b0; break; end
      pl_data = (idx < n) ? pay[idx] : 8'h00;
      rdy = pl_ready;
    end
  endtask

  task automatic drain();
    while (frames_rx < sent_cnt) @(posedge clk);
    repeat (20) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d frames", frames_rx, sent_cnt);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(tx_en == 1'b0, "R12 reset tx_en", int'(tx_en), 0);
    chk(txd == 8'h00, "R12 reset txd", int'(txd), 0);
    chk(pl_ready == 1'b0, "R12 reset pl_ready", int'(pl_ready), 0);
    rst_n = 1'b1;

    send_frame(0, -1);      // R6 full padding
    send_frame(17, -1);     // R6 one pad octet
    send_frame(18, -1);     // exact minimum, no pad
    drain();
    send_frame(1500, -1);   // R10 clamp
    drain();
    chk(last_len == 1526, "R10 clamped frame size", last_len, 1526);

    cfg_bcast = 1'b1;       // R9
    send_frame(30, -1);
    drain();
    cfg_bcast = 1'b0;

    send_frame(64, -1);     // R8 back-to-back
    send_frame(5, -1);
    drain();
    chk(last_gap == 12, "R8 back-to-back gap", last_gap, 12);

    send_frame(40, 10);     // R11 underrun
    send_frame(20, -1);
    drain();

    for (int f = 0; f < 16; f++) begin
      cfg_src_mac  = {$urandom, $urandom} & 48'hFEFF_FFFF_FFFF;
      cfg_dst_mac  = {$urandom, $urandom};
      cfg_src_ip   = $urandom;
      cfg_dst_ip   = $urandom;
      cfg_src_port = 16'($urandom);
      cfg_dst_port = 16'($urandom);
      cfg_bcast    = ($urandom % 4) == 0;
      send_frame(int'($urandom % 300), -1);
    end
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule